// File: doc/BRIEF.md
# BCD Seven-Segment Decoder Chain with Ripple Blanking

This block turns a row of 4-bit BCD digits into active-high segment patterns for seven-segment displays. Each digit cell has an active-low lamp test, an active-low ripple-blank input and a shared blanking node. That node works both as an overriding blanking input and as the cell's ripple-blank output. In logic it is the AND of the external blanking level and the cell's own zero-blank condition, and the segment logic uses the combined value. Codes ten to fifteen decode to fixed non-decimal glyphs, and code fifteen is fully dark.

The cells are chained to suppress leading zeros. The most significant cell has its ripple input tied low. Each cell's node feeds the ripple input of the next lower cell. The least significant cell has its ripple input tied high, so a value of zero still shows one "0". A free-running counter compared against a duty value pulses the blanking level of every cell, which sets the brightness.

Top module: `segdisp_chain`

## Requirements
- R1: Segments are active high. Digit i drives `seg[7i+6:7i]` as {g,f,e,d,c,b,a}, with segment a in bit 0, and it decodes `bcd[4i+3:4i]`. With its node high, lamp test high and no zero blanking, codes 0..9 give the decimal glyphs: 6 lights c,d,e,f,g; 7 lights only a,b,c; 9 lights a,b,c,f,g; 0 lights every segment except g.
- R2: Codes 10..15 light these segments: 10 lights d,e,g; 11 lights c,d,g; 12 lights b,f,g; 13 lights a,d,f,g; 14 lights d,e,f,g; 15 lights none.
- R3: While `blank_n` is low, every segment is low and every `ripple_n` bit is low, whatever the lamp test and BCD inputs are.
- R4: While `lamp_test_n` is low and a digit's node is high, all seven segments of that digit are lit, whatever its code and its ripple input.
- R5: A digit whose ripple input is low, whose code is 0 and whose lamp test is high has all segments dark and drives its node low. With its ripple input high, a zero shows normally.
- R6: `ripple_n[i]` is the node of digit i. It equals `blank_n` AND `lamp_on` AND NOT (that digit's zero-blank condition), and the segments of a digit are dark whenever its node is low.
- R7: Digit N-1 has its ripple input tied low. Digit i (0 < i < N-1) takes `ripple_n[i+1]`. Digit 0 has its ripple input tied high. Leading zeros are therefore blanked, inner zeros are shown, and an all-zero value shows a single "0" in digit 0.
- R8: Once reset is released, `lamp_on` is high in exactly `duty` cycles of every 256 consecutive cycles. A duty of 0 keeps it low, so the display is dark.
- R9: While `rst_n` is low, the counter is held at zero, so `lamp_on` equals (`duty` != 0). Reset is applied asynchronously and released after two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the brightness counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty | input | 8 | Brightness duty, lit cycles per 256 |
| lamp_test_n | input | 1 | Active-low lamp test to all digits |
| blank_n | input | 1 | Active-low forced blanking to all digits |
| bcd | input | 4*NUM_DIGITS | Digit codes, digit N-1 most significant |
| seg | output | 7*NUM_DIGITS | Active-high segments, {g..a} per digit |
| ripple_n | output | NUM_DIGITS | Blanking node of each digit |
| lamp_on | output | 1 | Brightness pulse driving every blanking input |

## Verification
The assertions sample the combinational outputs at the rising clock edge. They take for granted that `bcd`, `lamp_test_n`, `blank_n` and `duty` are steady around that edge, and that `duty` does not change within a window the counter checks rely on. The stimulus changes every input on the falling edge and reads the outputs shortly after it. Where segment checks need the blanking pulse high, the stimulus waits until `lamp_on` is high before sampling.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_DARK = '0;
  localparam seg_t SEG_ALL  = '1;

  // Glyph for one code, bit order {g,f,e,d,c,b,a}
  function automatic seg_t glyph(input logic [BCD_W-1:0] code);
    seg_t s;
    case (code)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111100;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1100111;
      4'd10:   s = 7'b1011000;
      4'd11:   s = 7'b1001100;
      4'd12:   s = 7'b1100010;
      4'd13:   s = 7'b1101001;
      4'd14:   s = 7'b1111000;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic stage_d;
  logic out_d;

  always_comb begin
    stage_d = 1'b1;
    out_d   = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_sync_n <= out_d;
    end
  end
endmodule

// File: rtl/seg_pwm.sv
module seg_pwm #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [DUTY_W-1:0] duty,
  output logic [DUTY_W-1:0] cnt,
  output logic              lamp_on
);
  logic [DUTY_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (cnt_en) cnt_d = cnt + {{(DUTY_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign lamp_on = (cnt < duty);
endmodule

// File: rtl/seg_digit.sv
module seg_digit
  import segdisp_pkg::*;
(
  input  logic [BCD_W-1:0] code,
  input  logic             lt_n,
  input  logic             rbi_n,
  input  logic             bi_n,
  output seg_t             seg,
  output logic             node_n
);
  logic zero_blank;

  assign zero_blank = !rbi_n && (code == '0) && lt_n;
  // wired-AND of the external blanking level and the local ripple output
  assign node_n = bi_n & ~zero_blank;

  always_comb begin
    if (!node_n)    seg = SEG_DARK;
    else if (!lt_n) seg = SEG_ALL;
    else            seg = glyph(code);
  end
endmodule

// File: rtl/segdisp_chain.sv
module segdisp_chain
  import segdisp_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DUTY_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DUTY_W-1:0]           duty,
  input  logic                        lamp_test_n,
  input  logic                        blank_n,
  input  logic [BCD_W*NUM_DIGITS-1:0] bcd,
  output logic [SEG_W*NUM_DIGITS-1:0] seg,
  output logic [NUM_DIGITS-1:0]       ripple_n,
  output logic                        lamp_on
);
  localparam int MSD = NUM_DIGITS - 1;

  logic              rst_sync_n;
  logic [DUTY_W-1:0] pwm_cnt;
  logic              cell_bi_n;

  seg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cnt_en  (1'b1),
    .duty    (duty),
    .cnt     (pwm_cnt),
    .lamp_on (lamp_on)
  );

  assign cell_bi_n = blank_n & lamp_on;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    logic rbi_n;
    if (i == 0) begin : g_lsd
      assign rbi_n = 1'b1;
    end else if (i == MSD) begin : g_msd
      assign rbi_n = 1'b0;
    end else begin : g_mid
      assign rbi_n = ripple_n[i+1];
    end

    seg_digit u_digit (
      .code   (bcd[BCD_W*i +: BCD_W]),
      .lt_n   (lamp_test_n),
      .rbi_n  (rbi_n),
      .bi_n   (cell_bi_n),
      .seg    (seg[SEG_W*i +: SEG_W]),
      .node_n (ripple_n[i])
    );
  end
endmodule

// File: rtl/segdisp_chain_chk.sv
module segdisp_chain_chk #(
  parameter int NUM_DIGITS = 4,
  parameter int DUTY_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_sync_n,
  input logic [DUTY_W-1:0]       duty,
  input logic [DUTY_W-1:0]       pwm_cnt,
  input logic                    lamp_on,
  input logic                    lamp_test_n,
  input logic                    blank_n,
  input logic [4*NUM_DIGITS-1:0] bcd,
  input logic [7*NUM_DIGITS-1:0] seg,
  input logic [NUM_DIGITS-1:0]   ripple_n
);
  localparam int MSD = NUM_DIGITS - 1;

  // R3
  blank_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (seg == '0 && ripple_n == '0));

  // R8
  duty_zero_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !lamp_on);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pwm_cnt != '1) |=> (pwm_cnt == $past(pwm_cnt) + {{(DUTY_W-1){1'b0}}, 1'b1}));

  // R8
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pwm_cnt == '1) |=> (pwm_cnt == '0));

  // R5
  msd_zero_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n && blank_n && lamp_on && bcd[4*MSD +: 4] == 4'd0)
      |-> (!ripple_n[MSD] && seg[7*MSD +: 7] == 7'd0));

  // R7
  lone_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n && blank_n && lamp_on && bcd[3:0] == 4'd0) |-> (seg[6:0] == 7'h3F));

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_chk
    // R4
    lamp_all_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lamp_test_n && ripple_n[i]) |-> (seg[7*i +: 7] == 7'h7F));
    // R6
    node_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ripple_n[i] |-> (seg[7*i +: 7] == 7'd0));
    // R2
    code15_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lamp_test_n && bcd[4*i +: 4] == 4'd15) |-> (seg[7*i +: 7] == 7'd0));
  end
endmodule

bind segdisp_chain segdisp_chain_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .DUTY_W     (DUTY_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .duty        (duty),
  .pwm_cnt     (pwm_cnt),
  .lamp_on     (lamp_on),
  .lamp_test_n (lamp_test_n),
  .blank_n     (blank_n),
  .bcd         (bcd),
  .seg         (seg),
  .ripple_n    (ripple_n)
);

// File: tb/segdisp_chain_bench.sv
module segdisp_chain_bench;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    duty;
  logic          lamp_test_n;
  logic          blank_n;
  logic [4*N-1:0] bcd;
  logic [7*N-1:0] seg;
  logic [N-1:0]  ripple_n;
  logic          lamp_on;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  segdisp_chain #(.NUM_DIGITS(N), .DUTY_W(8)) u_segdisp_chain (
    .clk (clk), .rst_n (rst_n), .duty (duty), .lamp_test_n (lamp_test_n),
    .blank_n (blank_n), .bcd (bcd), .seg (seg), .ripple_n (ripple_n),
    .lamp_on (lamp_on)
  );

  // expected glyph written in a..g order (a is the leftmost bit), returned as {g..a}
  function automatic logic [6:0] exp_glyph(input logic [3:0] c);
    logic [6:0] ag;
    logic [6:0] r;
    case (c)
      4'd0:  ag = 7'b1111110;
      4'd1:  ag = 7'b0110000;
      4'd2:  ag = 7'b1101101;
      4'd3:  ag = 7'b1111001;
      4'd4:  ag = 7'b0110011;
      4'd5:  ag = 7'b1011011;
      4'd6:  ag = 7'b0011111;
      4'd7:  ag = 7'b1110000;
      4'd8:  ag = 7'b1111111;
      4'd9:  ag = 7'b1110011;
      4'd10: ag = 7'b0001101;
      4'd11: ag = 7'b0011001;
      4'd12: ag = 7'b0100011;
      4'd13: ag = 7'b1001011;
      4'd14: ag = 7'b0001111;
      default: ag = 7'b0000000;
    endcase
    for (int k = 0; k < 7; k++) r[k] = ag[6-k];
    return r;
  endfunction

  task automatic model(input logic [4*N-1:0] b, input logic lt, input logic bl,
                       output logic [7*N-1:0] s, output logic [N-1:0] r);
    logic rbi;
    logic zb;
    for (int i = N-1; i >= 0; i--) begin
      if (i == 0)        rbi = 1'b1;
      else if (i == N-1) rbi = 1'b0;
      else               rbi = r[i+1];
      zb = !rbi && (b[4*i +: 4] == 4'd0) && lt;
      r[i] = bl && !zb;
      if (!r[i])   s[7*i +: 7] = 7'd0;
      else if (!lt) s[7*i +: 7] = 7'h7F;
      else          s[7*i +: 7] = exp_glyph(b[4*i +: 4]);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on the falling edge, wait for the brightness pulse, sample 1 ns later
  task automatic apply(input logic [4*N-1:0] b, input logic lt, input logic bl);
    @(negedge clk);
    bcd = b; lamp_test_n = lt; blank_n = bl;
    while (!lamp_on) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; duty = 8'd0; lamp_test_n = 1'b1; blank_n = 1'b1; bcd = '0;
    #12;
    chk("R9 lamp_on in reset duty0", {31'd0, lamp_on}, 32'd0);
    chk("R8 dark at duty0", {4'd0, seg}, 32'd0);
    duty = 8'd10;
    #1;
    chk("R9 lamp_on in reset duty10", {31'd0, lamp_on}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    duty = 8'd255;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_glyphs();
    for (int c = 0; c < 16; c++) begin
      apply({4'd8, 4'd8, 4'd8, 4'(c)}, 1'b1, 1'b1);
      if (c < 10) chk($sformatf("R1 code %0d", c), {25'd0, seg[6:0]}, {25'd0, exp_glyph(4'(c))});
      else        chk($sformatf("R2 code %0d", c), {25'd0, seg[6:0]}, {25'd0, exp_glyph(4'(c))});
    end
    apply(16'h8F00, 1'b1, 1'b1);
    chk("R5 inner zero shown", {25'd0, seg[13:7]}, 32'h3F);
    chk("R2 code15 dark", {25'd0, seg[20:14]}, 32'd0);
  endtask

  task automatic t_sweep();
    logic [7*N-1:0] es;
    logic [N-1:0]   er;
    for (int lt = 0; lt < 2; lt++)
      for (int bl = 0; bl < 2; bl++)
        for (int hi = 0; hi < 2; hi++)
          for (int c = 0; c < 16; c++) begin
            logic [4*N-1:0] b;
            b = {(hi != 0) ? 4'd3 : 4'd0, 4'(c), 4'd0, 4'(15 - c)};
            apply(b, 1'(lt), 1'(bl));
            model(b, 1'(lt), 1'(bl), es, er);
            if (bl == 0) chk("R3 blank overrides", {4'd0, seg}, {4'd0, es});
            else if (lt == 0) chk("R4 lamp test", {4'd0, seg}, {4'd0, es});
            else chk("R5 ripple sweep", {4'd0, seg}, {4'd0, es});
            chk("R6 node values", {28'd0, ripple_n}, {28'd0, er});
          end
  endtask

  task automatic t_chain();
    logic [7*N-1:0] es;
    logic [N-1:0]   er;
    logic [4*N-1:0] pats [5];
    pats[0] = 16'h0012; pats[1] = 16'h0000; pats[2] = 16'h1002;
    pats[3] = 16'h0102; pats[4] = 16'h0009;
    foreach (pats[p]) begin
      apply(pats[p], 1'b1, 1'b1);
      model(pats[p], 1'b1, 1'b1, es, er);
      chk($sformatf("R7 chain %h segs", pats[p]), {4'd0, seg}, {4'd0, es});
      chk($sformatf("R7 chain %h nodes", pats[p]), {28'd0, ripple_n}, {28'd0, er});
    end
    apply(16'h0000, 1'b1, 1'b1);
    chk("R7 lone zero", {4'd0, seg}, {4'd0, 21'd0, 7'h3F});
  endtask

  task automatic t_pwm();
    int duties [5] = '{0, 1, 64, 200, 255};
    foreach (duties[d]) begin
      int hits;
      @(negedge clk);
      duty = 8'(duties[d]);
      hits = 0;
      for (int k = 0; k < 256; k++) begin
        #1;
        if (lamp_on) hits++;
        @(negedge clk);
      end
      chk($sformatf("R8 duty %0d", duties[d]), hits, duties[d]);
      if (duties[d] == 0) begin
        bcd = 16'h1234; lamp_test_n = 1'b0; blank_n = 1'b1;
        #1;
        chk("R8 duty0 dark", {4'd0, seg}, 32'd0);
      end
    end
    duty = 8'd255;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_glyphs();
    t_sweep();
    t_chain();
    t_pwm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule